// File: doc/BRIEF.md
# Integer Shift and Word-Arithmetic Execution Unit

This unit decodes one 32-bit instruction word and executes it if it belongs to its set. The set holds the logical and arithmetic shifts by immediate and by register, and the 32-bit "word" operations of a 64-bit integer core: add, subtract and the three shifts in register form, and add plus the three shifts in immediate form. The integer register width is the parameter `XLEN`, set to 32 or 64. With `XLEN` = 32 the word operations do not exist, and the shift amount is five bits wide.

The unit takes the instruction and two source operand values on a valid/ready input channel. After one register stage it returns the result, the destination register index, a write enable and an illegal-encoding flag on a valid/ready output channel. The input accepts a beat when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a stall on `out_ready` stops new input only while a result is still held. A held result and its flags do not change until the result is consumed.

An instruction outside the set, or one whose encoding is invalid at the configured width, comes back marked illegal with no write. A legal instruction that targets register 0 also comes back with no write.

Top module: `shwu_unit`

## Requirements
- R1: Opcode 0010011 with funct3 001 and bits [31:26] = 000000 is a left shift, and funct3 101 is a logical right shift when bits [31:26] = 000000 or an arithmetic right shift when they are 010000. The shift amount is bits [25:20] at XLEN 64 and bits [24:20] at XLEN 32. The shift operates on all XLEN bits of operand A.
- R2: At XLEN 32, an immediate shift (opcode 0010011, funct3 001 or 101) with instruction bit 25 set is illegal.
- R3: Opcode 0110011 with funct7 0000000 and funct3 001, 0000000 and 101, or 0100000 and 101 gives a left, logical right or arithmetic right shift of operand A. The shift amount is the low 6 bits of operand B at XLEN 64 and the low 5 bits at XLEN 32.
- R4: At XLEN 64, opcode 0111011 gives the following on the low 32 bits of both operands: funct3 000 adds (funct7 0000000) or subtracts (funct7 0100000), funct3 001 shifts left, and funct3 101 shifts right logically (funct7 0000000) or arithmetically (funct7 0100000). The shift amount is operand B bits [4:0].
- R5: At XLEN 64, opcode 0011011 with funct3 000 adds the sign-extended immediate in bits [31:20] to operand A. With funct3 001 or 101 it shifts the low 32 bits of operand A by bits [24:20], and bits [31:25] pick the kind as in R4.
- R6: Every word operation (R4, R5) sign-extends bit 31 of its 32-bit result into the upper half of the result.
- R7: Any other encoding is illegal, including all of opcodes 0111011 and 0011011 at XLEN 32. An illegal result has `out_illegal` = 1, `out_wen` = 0 and a zero `out_result`.
- R8: `out_rd` carries instruction bits [11:7]. A legal instruction writing register 0 has `out_wen` = 0 and `out_illegal` = 0.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted beat appears on the output in the next cycle. A result that is not consumed keeps `out_valid` high and all output fields stable.
- R10: After reset `out_valid`, `out_wen` and `out_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat |
| in_instr | input | 32 | Instruction word |
| in_op_a | input | XLEN | First source operand |
| in_op_b | input | XLEN | Second source operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Computed value |
| out_wen | output | 1 | Destination write enable |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | Encoding not executable here |

## Verification
Several properties are checked on every cycle. The output is held steady under back-pressure, `in_ready` is high while the stage is empty, an illegal result is quiet, and a register-0 target never writes. The upper half of every word result is checked against its bit 31 at XLEN 64, and no word operation is legal at XLEN 32. Only the bench scenarios can show that each result value is correct. That covers which operand bits feed the shift amount at each width, overflow of the word add, immediate sign extension and the decoding of bad funct fields. The bench runs a 64-bit and a 32-bit instance side by side on the same stimulus.

// File: rtl/shwu_pkg.sv
package shwu_pkg;

  typedef enum logic [2:0] {
    ALU_SLL = 3'd0,
    ALU_SRL = 3'd1,
    ALU_SRA = 3'd2,
    ALU_ADD = 3'd3,
    ALU_SUB = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    legal;
    logic    word;
    logic    use_imm;
    alu_op_e op;
    logic [4:0] rd;
  } dec_t;

  localparam logic [6:0] OPC_SH_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_SH_REG  = 7'b0110011;
  localparam logic [6:0] OPC_W_IMM   = 7'b0011011;
  localparam logic [6:0] OPC_W_REG   = 7'b0111011;

  localparam logic [2:0] F3_ADD      = 3'b000;
  localparam logic [2:0] F3_LEFT     = 3'b001;
  localparam logic [2:0] F3_RIGHT    = 3'b101;

  localparam logic [6:0] F7_BASE     = 7'b0000000;
  localparam logic [6:0] F7_ALT      = 7'b0100000;
  localparam logic [5:0] F6_BASE     = 6'b000000;
  localparam logic [5:0] F6_ALT      = 6'b010000;

endpackage

// File: rtl/shwu_decode.sv
module shwu_decode
  import shwu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] instr,
  output dec_t        dec
);

  localparam bit WIDE = (XLEN == 64);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [5:0] f6;
  logic       unused_rs1;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];
  assign f6  = instr[31:26];
  assign unused_rs1 = ^instr[19:15];

  always_comb begin
    dec         = '0;
    dec.op      = ALU_SLL;
    dec.rd      = instr[11:7];
    unique case (opc)
      OPC_SH_IMM: begin
        dec.use_imm = 1'b1;
        if (f3 == F3_LEFT && f6 == F6_BASE) begin
          dec.legal = 1'b1;
          dec.op    = ALU_SLL;
        end else if (f3 == F3_RIGHT && f6 == F6_BASE) begin
          dec.legal = 1'b1;
          dec.op    = ALU_SRL;
        end else if (f3 == F3_RIGHT && f6 == F6_ALT) begin
          dec.legal = 1'b1;
          dec.op    = ALU_SRA;
        end
        if (!WIDE && instr[25]) dec.legal = 1'b0;
      end
      OPC_SH_REG: begin
        if (f3 == F3_LEFT && f7 == F7_BASE) begin
          dec.legal = 1'b1;
          dec.op    = ALU_SLL;
        end else if (f3 == F3_RIGHT && f7 == F7_BASE) begin
          dec.legal = 1'b1;
          dec.op    = ALU_SRL;
        end else if (f3 == F3_RIGHT && f7 == F7_ALT) begin
          dec.legal = 1'b1;
          dec.op    = ALU_SRA;
        end
      end
      OPC_W_REG: begin
        dec.word = 1'b1;
        if (WIDE) begin
          if (f3 == F3_ADD && f7 == F7_BASE) begin
            dec.legal = 1'b1;
            dec.op    = ALU_ADD;
          end else if (f3 == F3_ADD && f7 == F7_ALT) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SUB;
          end else if (f3 == F3_LEFT && f7 == F7_BASE) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SLL;
          end else if (f3 == F3_RIGHT && f7 == F7_BASE) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SRL;
          end else if (f3 == F3_RIGHT && f7 == F7_ALT) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SRA;
          end
        end
      end
      OPC_W_IMM: begin
        dec.word    = 1'b1;
        dec.use_imm = 1'b1;
        if (WIDE) begin
          if (f3 == F3_ADD) begin
            dec.legal = 1'b1;
            dec.op    = ALU_ADD;
          end else if (f3 == F3_LEFT && f7 == F7_BASE) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SLL;
          end else if (f3 == F3_RIGHT && f7 == F7_BASE) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SRL;
          end else if (f3 == F3_RIGHT && f7 == F7_ALT) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SRA;
          end
        end
      end
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/shwu_alu.sv
module shwu_alu
  import shwu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  alu_op_e           op,
  input  logic              word,
  input  logic              use_imm,
  input  logic [11:0]       imm12,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  output logic [XLEN-1:0]   result
);

  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0]  sh_full;
  logic [XLEN-1:0] full_res;
  logic [XLEN-1:0] word_res;
  logic            unused_in;

  assign unused_in = ^{imm12, op_b};
  assign sh_full   = use_imm ? imm12[SHW-1:0] : op_b[SHW-1:0];

  always_comb begin
    unique case (op)
      ALU_SLL: full_res = op_a << sh_full;
      ALU_SRL: full_res = op_a >> sh_full;
      ALU_SRA: full_res = $signed(op_a) >>> sh_full;
      default: full_res = '0;
    endcase
  end

  generate
    if (XLEN > 32) begin : g_word
      logic [31:0] a32;
      logic [31:0] b32;
      logic [4:0]  sh5;
      logic [31:0] w32;

      assign a32 = op_a[31:0];
      assign b32 = use_imm ? {{20{imm12[11]}}, imm12} : op_b[31:0];
      assign sh5 = use_imm ? imm12[4:0] : op_b[4:0];

      always_comb begin
        unique case (op)
          ALU_ADD: w32 = a32 + b32;
          ALU_SUB: w32 = a32 - b32;
          ALU_SLL: w32 = a32 << sh5;
          ALU_SRL: w32 = a32 >> sh5;
          ALU_SRA: w32 = $signed(a32) >>> sh5;
          default: w32 = '0;
        endcase
      end

      assign word_res = {{(XLEN-32){w32[31]}}, w32};
    end else begin : g_noword
      assign word_res = '0;
    end
  endgenerate

  assign result = word ? word_res : full_res;

endmodule

// File: rtl/shwu_unit.sv
module shwu_unit
  import shwu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_op_a,
  input  logic [XLEN-1:0] in_op_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_wen,
  output logic [4:0]      out_rd,
  output logic            out_illegal
);

  dec_t            dec;
  logic [XLEN-1:0] alu_res;
  logic            take;
  logic            word_q;

  shwu_decode #(.XLEN(XLEN)) u_decode (
    .instr (in_instr),
    .dec   (dec)
  );

  shwu_alu #(.XLEN(XLEN)) u_alu (
    .op      (dec.op),
    .word    (dec.word),
    .use_imm (dec.use_imm),
    .imm12   (in_instr[31:20]),
    .op_a    (in_op_a),
    .op_b    (in_op_b),
    .result  (alu_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wen     <= 1'b0;
      out_rd      <= '0;
      out_illegal <= 1'b0;
      word_q      <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= dec.legal ? alu_res : '0;
        out_wen     <= dec.legal && (dec.rd != 5'd0);
        out_rd      <= dec.rd;
        out_illegal <= !dec.legal;
        word_q      <= dec.word;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wen) && $stable(out_rd) && $stable(out_illegal)); // R9

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wen && (out_result == '0)); // R7

  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_rd == 5'd0) |-> !out_wen); // R8

  generate
    if (XLEN > 32) begin : g_chk_wide
      AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && word_q |-> out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}); // R6
    end else begin : g_chk_narrow
      AST_NO_WORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && word_q |-> out_illegal); // R7
    end
  endgenerate

endmodule

// File: tb/shwu_unit_bench.sv
`timescale 1ns/1ps
module shwu_unit_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;

  logic        ir64, ov64, wen64, ill64;
  logic [63:0] res64;
  logic [4:0]  rd64;
  logic        ir32, ov32, wen32, ill32;
  logic [31:0] res32;
  logic [4:0]  rd32;

  shwu_unit #(.XLEN(64)) u_shwu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir64),
    .in_instr(instr), .in_op_a(op_a), .in_op_b(op_b),
    .out_valid(ov64), .out_ready(out_ready), .out_result(res64),
    .out_wen(wen64), .out_rd(rd64), .out_illegal(ill64)
  );

  shwu_unit #(.XLEN(32)) u_shwu_unit_x32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir32),
    .in_instr(instr), .in_op_a(op_a[31:0]), .in_op_b(op_b[31:0]),
    .out_valid(ov32), .out_ready(out_ready), .out_result(res32),
    .out_wen(wen32), .out_rd(rd32), .out_illegal(ill32)
  );

  int total = 0;
  int bad = 0;

  // model state: one stage, {illegal, wen, result}
  logic        mv = 1'b0;
  logic [65:0] e64 = '0;
  logic [65:0] e32 = '0;
  logic [31:0] mins = '0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [65:0] ref_exec(input int xl, input logic [31:0] ins,
                                           input logic [63:0] a, input logic [63:0] b);
    logic [6:0]  opc = ins[6:0];
    logic [2:0]  f3  = ins[14:12];
    logic [6:0]  f7  = ins[31:25];
    logic [5:0]  f6  = ins[31:26];
    logic        ok  = 1'b0;
    logic [63:0] r   = '0;
    logic [31:0] a32 = a[31:0];
    logic [31:0] t32;
    int          sh;
    int          kind = -1; // 0 left, 1 logical right, 2 arith right
    if (opc == 7'h13) begin
      sh = (xl == 64) ? int'(ins[25:20]) : int'(ins[24:20]);
      if (f3 == 3'b001 && f6 == 6'h00) kind = 0;
      else if (f3 == 3'b101 && f6 == 6'h00) kind = 1;
      else if (f3 == 3'b101 && f6 == 6'h10) kind = 2;
      if (xl == 32 && ins[25]) kind = -1;
    end else if (opc == 7'h33) begin
      sh = (xl == 64) ? int'(b[5:0]) : int'(b[4:0]);
      if (f3 == 3'b001 && f7 == 7'h00) kind = 0;
      else if (f3 == 3'b101 && f7 == 7'h00) kind = 1;
      else if (f3 == 3'b101 && f7 == 7'h20) kind = 2;
    end
    if (kind >= 0) begin
      ok = 1'b1;
      if (xl == 64) begin
        case (kind)
          0: r = a << sh;
          1: r = a >> sh;
          default: r = $signed(a) >>> sh;
        endcase
      end else begin
        case (kind)
          0: t32 = a32 << sh;
          1: t32 = a32 >> sh;
          default: t32 = $signed(a32) >>> sh;
        endcase
        r = {32'h0, t32};
      end
    end
    if (xl == 64 && (opc == 7'h3B || opc == 7'h1B)) begin
      logic [31:0] bb;
      int s5;
      if (opc == 7'h3B) begin
        bb = b[31:0];
        s5 = int'(b[4:0]);
      end else begin
        bb = {{20{ins[31]}}, ins[31:20]};
        s5 = int'(ins[24:20]);
      end
      ok = 1'b1;
      if (f3 == 3'b000 && (opc == 7'h1B || f7 == 7'h00)) t32 = a32 + bb;
      else if (f3 == 3'b000 && f7 == 7'h20) t32 = a32 - bb;
      else if (f3 == 3'b001 && f7 == 7'h00) t32 = a32 << s5;
      else if (f3 == 3'b101 && f7 == 7'h00) t32 = a32 >> s5;
      else if (f3 == 3'b101 && f7 == 7'h20) t32 = $signed(a32) >>> s5;
      else ok = 1'b0;
      r = ok ? sx32(t32) : 64'h0;
    end
    if (!ok) r = '0;
    return {!ok, ok && (ins[11:7] != 5'd0), r};
  endfunction

  function automatic string tag(input int xl, input logic [31:0] ins, input logic [65:0] e);
    logic [6:0] opc = ins[6:0];
    if (!e[65] && ins[11:7] == 5'd0) return "R8";
    if (opc == 7'h13) return (xl == 32 && ins[25]) ? "R2" : (e[65] ? "R7" : "R1");
    if (opc == 7'h33) return e[65] ? "R7" : "R3";
    if (xl == 64 && !e[65] && e[31]) return "R6";
    if (xl == 64 && !e[65] && opc == 7'h3B) return "R4";
    if (xl == 64 && !e[65] && opc == 7'h1B) return "R5";
    return "R7";
  endfunction

  task automatic step(input logic v, input logic r, input logic [31:0] ins,
                      input logic [63:0] a, input logic [63:0] b);
    logic acc;
    string t;
    @(negedge clk);
    chk("R9", "valid64", {63'h0, ov64}, {63'h0, mv});
    chk("R9", "valid32", {63'h0, ov32}, {63'h0, mv});
    if (mv) begin
      t = tag(64, mins, e64);
      chk(t, "result64", res64, e64[63:0]);
      chk(t, "wen64", {63'h0, wen64}, {63'h0, e64[64]});
      chk(t, "illegal64", {63'h0, ill64}, {63'h0, e64[65]});
      chk("R8", "rd64", {59'h0, rd64}, {59'h0, mins[11:7]});
      t = tag(32, mins, e32);
      chk(t, "result32", {32'h0, res32}, {32'h0, e32[31:0]});
      chk(t, "wen32", {63'h0, wen32}, {63'h0, e32[64]});
      chk(t, "illegal32", {63'h0, ill32}, {63'h0, e32[65]});
      chk("R8", "rd32", {59'h0, rd32}, {59'h0, mins[11:7]});
    end
    in_valid = v; out_ready = r; instr = ins; op_a = a; op_b = b;
    #1;
    chk("R9", "in_ready64", {63'h0, ir64}, {63'h0, (!mv || r)});
    chk("R9", "in_ready32", {63'h0, ir32}, {63'h0, (!mv || r)});
    acc = v && (!mv || r);
    if (mv && r) mv = 1'b0;
    if (acc) begin
      mv   = 1'b1;
      e64  = ref_exec(64, ins, a, b);
      e32  = ref_exec(32, ins, a, b);
      mins = ins;
    end
  endtask

  function automatic logic [31:0] e_sh(input logic [5:0] f6, input logic [5:0] sh,
                                       input logic [2:0] f3, input logic [4:0] rd);
    return {f6, sh, 5'd1, f3, rd, 7'h13};
  endfunction

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] e_iw(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
    return {imm, 5'd1, f3, rd, 7'h1B};
  endfunction

  function automatic logic [2:0] pick_f3();
    int k = $urandom_range(0, 3);
    if (k == 0) return 3'b000;
    if (k == 1) return 3'b001;
    if (k == 2) return 3'b101;
    return 3'($urandom);
  endfunction

  function automatic logic [6:0] pick_f7();
    int k = $urandom_range(0, 4);
    if (k < 2) return 7'h00;
    if (k < 4) return 7'h20;
    return 7'($urandom);
  endfunction

  function automatic logic [31:0] rnd_instr();
    int k = $urandom_range(0, 4);
    logic [4:0] rd = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom);
    logic [5:0] f6;
    logic [31:0] w;
    case (k)
      0: begin
        f6 = ($urandom_range(0, 3) == 0) ? 6'($urandom) : (($urandom_range(0, 1) == 0) ? 6'h00 : 6'h10);
        w = e_sh(f6, 6'($urandom), pick_f3(), rd);
      end
      1: w = e_r(pick_f7(), pick_f3(), rd, 7'h33);
      2: w = e_r(pick_f7(), pick_f3(), rd, 7'h3B);
      3: w = {pick_f7(), 5'($urandom), 5'd1, pick_f3(), rd, 7'h1B};
      default: w = {$urandom} | 32'h3;
    endcase
    return w;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  localparam logic [63:0] PAT = 64'h8000_0000_F000_00F1;
  localparam logic [63:0] BSH = 64'hFFFF_FFFF_FFFF_FFE5;

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "valid64", {63'h0, ov64}, 64'h0);
    chk("R10", "valid32", {63'h0, ov32}, 64'h0);
    chk("R10", "wen64", {63'h0, wen64}, 64'h0);
    chk("R10", "illegal64", {63'h0, ill64}, 64'h0);
    chk("R10", "illegal32", {63'h0, ill32}, 64'h0);
    rst_n = 1'b1;

    // R1 / R2 immediate shifts
    step(1, 1, e_sh(6'h00, 6'd0, 3'b001, 5'd5), PAT, 64'h0);
    step(1, 1, e_sh(6'h00, 6'd63, 3'b001, 5'd5), PAT, 64'h0);
    step(1, 1, e_sh(6'h10, 6'd40, 3'b101, 5'd6), PAT, 64'h0);
    step(1, 1, e_sh(6'h10, 6'd31, 3'b101, 5'd6), PAT, 64'h0);
    step(1, 1, e_sh(6'h00, 6'd7, 3'b101, 5'd7), PAT, 64'h0);
    step(1, 1, e_sh(6'h01, 6'd3, 3'b101, 5'd7), PAT, 64'h0);
    // R3 register shifts, upper bits of B ignored
    step(1, 1, e_r(7'h00, 3'b001, 5'd8, 7'h33), PAT, BSH);
    step(1, 1, e_r(7'h20, 3'b101, 5'd8, 7'h33), PAT, BSH);
    step(1, 1, e_r(7'h00, 3'b101, 5'd8, 7'h33), PAT, BSH);
    // R4 / R6 word register operations
    step(1, 1, e_r(7'h00, 3'b000, 5'd9, 7'h3B), 64'h0000_0000_7FFF_FFFF, 64'h1);
    step(1, 1, e_r(7'h20, 3'b000, 5'd9, 7'h3B), 64'h0, 64'h1);
    step(1, 1, e_r(7'h00, 3'b001, 5'd9, 7'h3B), PAT, 64'h21);
    step(1, 1, e_r(7'h00, 3'b101, 5'd9, 7'h3B), PAT, 64'h4);
    step(1, 1, e_r(7'h20, 3'b101, 5'd9, 7'h3B), PAT, 64'h4);
    // R5 word immediate operations
    step(1, 1, e_iw(12'hFFF, 3'b000, 5'd10), 64'h0, 64'h0);
    step(1, 1, e_iw(12'h800, 3'b000, 5'd10), 64'h1_0000_0000, 64'h0);
    step(1, 1, e_iw({7'h00, 5'd31}, 3'b001, 5'd10), 64'h1, 64'h0);
    step(1, 1, e_iw({7'h20, 5'd4}, 3'b101, 5'd10), PAT, 64'h0);
    step(1, 1, e_iw({7'h00, 5'd4}, 3'b101, 5'd10), PAT, 64'h0);
    step(1, 1, e_iw({7'h01, 5'd4}, 3'b101, 5'd10), PAT, 64'h0);
    // R8 register 0, R7 out-of-set encoding
    step(1, 1, e_sh(6'h00, 6'd3, 3'b001, 5'd0), PAT, 64'h0);
    step(1, 1, e_r(7'h00, 3'b000, 5'd11, 7'h33), PAT, 64'h1);
    // R9 back-pressure: result held, new input refused
    step(1, 0, e_r(7'h00, 3'b000, 5'd12, 7'h3B), 64'h5, 64'h6);
    step(1, 0, e_r(7'h20, 3'b000, 5'd12, 7'h3B), 64'h5, 64'h6);
    step(1, 0, e_r(7'h20, 3'b000, 5'd12, 7'h3B), 64'h5, 64'h6);
    step(0, 1, 32'h0, 64'h0, 64'h0);
    step(0, 1, 32'h0, 64'h0, 64'h0);

    for (int i = 0; i < 4000; i++) begin
      logic v = ($urandom_range(0, 3) != 0);
      logic r = ($urandom_range(0, 3) != 0);
      step(v, r, rnd_instr(), rnd64(), rnd64());
    end

    repeat (3) step(0, 1, 32'h0, 64'h0, 64'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule